// File: doc/BRIEF.md
# Per-Warp Hit-Ratio Classifier

This block watches the stream of shared-cache lookup outcomes and learns, for every warp, how often its accesses find their data in the cache. Each lookup carries a warp number and a hit-or-miss flag. For each warp the block keeps two saturating counters: accesses and hits. When a profiling interval ends, it turns each warp's two counts into one of five locality classes. It then clears the counters so that every warp is profiled again from zero.

Downstream logic uses the class to steer that warp's traffic, for example to decide on bypassing, insertion position or request priority. It reads the class through a query port: the caller presents a warp number and gets a 3-bit code back in the same cycle. The class changes only at an interval boundary, so it holds steady for a whole interval. No divider is used. Each threshold is a fraction num/den, and the test `hits*den` against `accesses*num` stands in for the division. The thresholds, the counter width, the number of warps and the interval length are parameters.

Top module: `warp_locality_classifier`

## Requirements
- R1: The query port returns, in the same cycle and with no register on the path, the class code stored for the warp on `qry_warp`. The codes are 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss and 4 all-miss, and no other value appears.
- R2: After reset every warp reports code 2 (balanced), and every counter is zero.
- R3: A warp with at least one access and no misses in the finished interval is classed 0 (all-hit).
- R4: A warp with at least one access and zero hits in the finished interval is classed 4 (all-miss).
- R5: A warp that meets neither R3 nor R4 is classed 1 (mostly-hit) when `hits*HI_DEN >= accesses*HI_NUM`. The default threshold is 7/10, and exactly 70 % counts as mostly-hit.
- R6: A warp that meets none of R3, R4 or R5 is classed 3 (mostly-miss) when `hits*LO_DEN <= accesses*LO_NUM`. The default threshold is 2/10, and exactly 20 % counts as mostly-miss.
- R7: A warp that had no accesses in the finished interval, or that meets none of R3 to R6, is classed 2 (balanced).
- R8: The access counter saturates at its maximum, 2^CNT_W-1. Once it is full, further lookups for that warp change neither of its counts until the interval ends.
- R9: Every INTERVAL cycles after reset, in the last cycle of each interval, the classes take the values derived from that interval's counts and all counters clear.
- R10: A lookup that arrives in the boundary cycle is dropped. It counts toward neither the finished interval nor the new one.
- R11: Between two boundaries no class changes, whatever lookups arrive.
- R12: A lookup affects only the counters of the warp it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A cache lookup result is present this cycle |
| lk_warp | input | WID_W | Warp that issued the lookup |
| lk_hit | input | 1 | 1 = lookup hit, 0 = lookup missed |
| qry_warp | input | WID_W | Warp whose class is requested |
| qry_class | output | 3 | Class code of `qry_warp` (0 all-hit to 4 all-miss) |

## Verification
The bench runs a series of profiling intervals on four warps, with the mix of hits and misses per warp chosen differently each time. It then reads back every warp's class at the start of the following interval. The mixes sit exactly on the 70 % and 20 % thresholds and just below or above them, which separates an inclusive comparison from an off-by-one. Pure-hit, pure-miss and idle warps separate the three cases that lead to code 0, 4 and 2. One interval overfills two warps with hits placed first, so that a counter that wraps instead of saturating gives a different class. A lookup placed on the boundary cycle for an otherwise idle warp shows whether the boundary takes precedence. A mid-interval read and a final empty interval confirm that classes hold between boundaries and are re-learned after one.

// File: rtl/wlc_pkg.sv
// Package: shared class encoding for the warp locality classifier.
// Assumes: the numeric order of the codes follows locality, from best to worst.
package wlc_pkg;

    typedef enum logic [2:0] {
        LC_ALL_HIT      = 3'd0,
        LC_MOSTLY_HIT   = 3'd1,
        LC_BALANCED     = 3'd2,
        LC_MOSTLY_MISS  = 3'd3,
        LC_ALL_MISS     = 3'd4
    } loc_class_e;

    localparam int unsigned CLASS_W = 3;

endpackage

// File: rtl/wlc_interval_timer.sv
// Module: wlc_interval_timer
// Counts clock cycles and raises `tick` for one cycle in the last cycle of
// every profiling interval of INTERVAL cycles.
// Assumes: INTERVAL >= 2; the counter restarts from zero on reset.
module wlc_interval_timer #(
    parameter int unsigned INTERVAL = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Advance the cycle count and wrap to zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wlc_warp_stats.sv
// Module: wlc_warp_stats
// Holds the hit and access counters of one warp.
// Assumes: `clr` takes precedence over `inc`. When the access counter is full,
// the lookup is ignored so that hits never exceed accesses.
module wlc_warp_stats #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             hit,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] acc
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic full;
    assign full = (acc == CNT_MAX);

    // Clear at the boundary, otherwise count accepted lookups without overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits <= '0;
            acc  <= '0;
        end else if (clr) begin
            hits <= '0;
            acc  <= '0;
        end else if (inc && !full) begin
            acc <= acc + 1'b1;
            if (hit) begin
                hits <= hits + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wlc_ratio_decide.sv
// Module: wlc_ratio_decide
// Combinational mapping from a warp's (hits, accesses) to a locality class.
// Ratios are compared by cross-multiplication, so no divider is needed.
// Assumes: hits <= acc; thresholds satisfy LO_NUM/LO_DEN < HI_NUM/HI_DEN.
module wlc_ratio_decide
    import wlc_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned HI_NUM = 7,
    parameter int unsigned HI_DEN = 10,
    parameter int unsigned LO_NUM = 2,
    parameter int unsigned LO_DEN = 10
) (
    input  logic [CNT_W-1:0]   hits,
    input  logic [CNT_W-1:0]   acc,
    output logic [CLASS_W-1:0] cls
);
    localparam int unsigned PROD_W = CNT_W + 16;

    logic [PROD_W-1:0] hit_hi, acc_hi, hit_lo, acc_lo;

    // Scale both sides of each threshold comparison.
    always_comb begin
        hit_hi = PROD_W'(hits) * PROD_W'(HI_DEN);
        acc_hi = PROD_W'(acc)  * PROD_W'(HI_NUM);
        hit_lo = PROD_W'(hits) * PROD_W'(LO_DEN);
        acc_lo = PROD_W'(acc)  * PROD_W'(LO_NUM);
    end

    // Pick the class; the exact cases come before the ratio bands.
    always_comb begin
        if (acc == '0) begin
            cls = LC_BALANCED;
        end else if (hits == acc) begin
            cls = LC_ALL_HIT;
        end else if (hits == '0) begin
            cls = LC_ALL_MISS;
        end else if (hit_hi >= acc_hi) begin
            cls = LC_MOSTLY_HIT;
        end else if (hit_lo <= acc_lo) begin
            cls = LC_MOSTLY_MISS;
        end else begin
            cls = LC_BALANCED;
        end
    end

endmodule

// File: rtl/warp_locality_classifier.sv
// Module: warp_locality_classifier (top)
// Profiles each warp's shared-cache hit ratio over fixed intervals. At each
// interval boundary it latches a five-level locality class per warp and
// clears the statistics. The query port reads the latched class in the same cycle.
// Assumes: at most one lookup per cycle; a lookup in the boundary cycle is dropped.
module warp_locality_classifier
    import wlc_pkg::*;
#(
    parameter int unsigned NUM_WARPS = 32,
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned INTERVAL  = 4096,
    parameter int unsigned HI_NUM    = 7,
    parameter int unsigned HI_DEN    = 10,
    parameter int unsigned LO_NUM    = 2,
    parameter int unsigned LO_DEN    = 10,
    localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [WID_W-1:0] lk_warp,
    input  logic             lk_hit,
    input  logic [WID_W-1:0] qry_warp,
    output logic [2:0]       qry_class
);
    logic                           tick;
    logic [NUM_WARPS*CNT_W-1:0]     hit_flat;
    logic [NUM_WARPS*CNT_W-1:0]     acc_flat;
    logic [NUM_WARPS*CLASS_W-1:0]   next_flat;
    logic [NUM_WARPS*CLASS_W-1:0]   cls_flat;

    wlc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        logic sel;
        assign sel = lk_valid && (lk_warp == WID_W'(g)) && !tick;

        wlc_warp_stats #(.CNT_W(CNT_W)) u_stats (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (tick),
            .inc   (sel),
            .hit   (lk_hit),
            .hits  (hit_flat[g*CNT_W +: CNT_W]),
            .acc   (acc_flat[g*CNT_W +: CNT_W])
        );

        wlc_ratio_decide #(
            .CNT_W  (CNT_W),
            .HI_NUM (HI_NUM),
            .HI_DEN (HI_DEN),
            .LO_NUM (LO_NUM),
            .LO_DEN (LO_DEN)
        ) u_decide (
            .hits (hit_flat[g*CNT_W +: CNT_W]),
            .acc  (acc_flat[g*CNT_W +: CNT_W]),
            .cls  (next_flat[g*CLASS_W +: CLASS_W])
        );

        // Hold the class for the whole interval; reload only at the boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cls_flat[g*CLASS_W +: CLASS_W] <= LC_BALANCED;
            end else if (tick) begin
                cls_flat[g*CLASS_W +: CLASS_W] <= next_flat[g*CLASS_W +: CLASS_W];
            end
        end
    end

    // Combinational read of the addressed warp's class.
    always_comb begin
        qry_class = cls_flat[qry_warp*CLASS_W +: CLASS_W];
    end

endmodule

// File: rtl/wlc_checker.sv
// Module: wlc_checker
// Temporal checks on the classifier's internal state, attached with bind.
// Assumes: the observed vectors are the top's flat counter and class vectors.
module wlc_checker #(
    parameter int unsigned NUM_WARPS = 32,
    parameter int unsigned CNT_W     = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic [NUM_WARPS*CNT_W-1:0]   hit_flat,
    input logic [NUM_WARPS*CNT_W-1:0]   acc_flat,
    input logic [NUM_WARPS*3-1:0]       cls_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R9: the cycle after a boundary, every counter is clear.
    assert_boundary_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (acc_flat == '0 && hit_flat == '0))
        else $error("boundary did not clear counters");

    // R9: boundaries are isolated single-cycle events.
    assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("boundary lasted more than one cycle");

    // R11: classes move only at a boundary.
    assert_class_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cls_flat))
        else $error("class changed inside an interval");

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_chk
        // R8: hits never exceed accesses.
        assert_hits_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit_flat[g*CNT_W +: CNT_W] <= acc_flat[g*CNT_W +: CNT_W])
            else $error("hits exceed accesses");

        // R8: a full access counter stays full until the boundary.
        assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_flat[g*CNT_W +: CNT_W] == CNT_MAX && !tick)
            |=> acc_flat[g*CNT_W +: CNT_W] == CNT_MAX)
            else $error("access counter wrapped");

        // R12: at most one access is added per warp per cycle.
        assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> (acc_flat[g*CNT_W +: CNT_W] == $past(acc_flat[g*CNT_W +: CNT_W]) ||
                       acc_flat[g*CNT_W +: CNT_W] == CNT_W'($past(acc_flat[g*CNT_W +: CNT_W]) + 1'b1)))
            else $error("access counter stepped by more than one");

        // R1: only the five defined codes are stored.
        assert_class_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
            cls_flat[g*3 +: 3] <= 3'd4)
            else $error("illegal class code");
    end

endmodule

bind warp_locality_classifier wlc_checker #(
    .NUM_WARPS (NUM_WARPS),
    .CNT_W     (CNT_W)
) u_wlc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .hit_flat (hit_flat),
    .acc_flat (acc_flat),
    .cls_flat (cls_flat)
);

// File: tb/tb_warp_locality_classifier.sv
// Bench: runs whole profiling intervals on four warps with 4-bit counters.
// Each interval's classes are read back at the start of the next interval and
// compared with values computed arithmetically from the requirements.
module tb_warp_locality_classifier;

    localparam int NW  = 4;
    localparam int CW  = 4;
    localparam int IV  = 80;
    localparam int MAXC = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 1'b0;
    logic [1:0] lk_warp = '0;
    logic       lk_hit = 1'b0;
    logic [1:0] qry_warp = '0;
    logic [2:0] qry_class;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int    cur_h [NW];
    int    cur_m [NW];
    int    prev_h [NW];
    int    prev_m [NW];
    string cur_tag [NW];
    string prev_tag [NW];
    logic [1:0] sch_w [IV];
    logic       sch_h [IV];
    int         sch_n;

    always #5 clk = ~clk;

    warp_locality_classifier #(
        .NUM_WARPS (NW),
        .CNT_W     (CW),
        .INTERVAL  (IV)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_warp   (lk_warp),
        .lk_hit    (lk_hit),
        .qry_warp  (qry_warp),
        .qry_class (qry_class)
    );

    // Expected class from hit/miss counts offered in order hits then misses.
    function automatic int exp_class(input int h, input int m);
        int a, hs;
        a  = (h + m > MAXC) ? MAXC : h + m;
        hs = (h > a) ? a : h;
        if (a == 0)                return 2;
        else if (hs == a)          return 0;
        else if (hs == 0)          return 4;
        else if (hs * 10 >= a * 7) return 1;
        else if (hs * 10 <= a * 2) return 3;
        else                       return 2;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One full interval: read back previous classes, then issue this pattern.
    task automatic run_interval(input bit lookup_on_boundary);
        sch_n = 0;
        for (int w = 0; w < NW; w++) begin
            for (int k = 0; k < cur_h[w]; k++) begin
                sch_w[sch_n] = 2'(w); sch_h[sch_n] = 1'b1; sch_n++;
            end
            for (int k = 0; k < cur_m[w]; k++) begin
                sch_w[sch_n] = 2'(w); sch_h[sch_n] = 1'b0; sch_n++;
            end
        end
        for (int c = 0; c < IV; c++) begin
            lk_valid = 1'b0;
            if (c < NW) begin
                qry_warp = 2'(c);
                #1;
                check(prev_tag[c], int'(qry_class), exp_class(prev_h[c], prev_m[c]));
            end else if (c - NW < sch_n) begin
                lk_valid = 1'b1;
                lk_warp  = sch_w[c - NW];
                lk_hit   = sch_h[c - NW];
            end
            if (c == IV - 2) begin
                // R11: class still reflects the previous interval.
                qry_warp = 2'd0;
                #1;
                check("R11", int'(qry_class), exp_class(prev_h[0], prev_m[0]));
            end
            if (c == IV - 1 && lookup_on_boundary) begin
                // R10: this lookup lands on the boundary cycle.
                lk_valid = 1'b1; lk_warp = 2'd1; lk_hit = 1'b1;
            end
            @(negedge clk);
        end
        lk_valid = 1'b0;
        for (int w = 0; w < NW; w++) begin
            prev_h[w] = cur_h[w]; prev_m[w] = cur_m[w]; prev_tag[w] = cur_tag[w];
        end
    endtask

    task automatic set_pat(input int w, input int h, input int m, input string t);
        cur_h[w] = h; cur_m[w] = m; cur_tag[w] = t;
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            prev_h[w] = 0; prev_m[w] = 0; prev_tag[w] = "R2";
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5 R6 at the exact thresholds; R12 independent warps; R1 query.
        set_pat(0, 5, 0, "R3");
        set_pat(1, 0, 4, "R4");
        set_pat(2, 7, 3, "R5_R12");
        set_pat(3, 2, 8, "R6_R1");
        run_interval(1'b0);

        // R7 bands between thresholds; R10 boundary lookup on idle warp 1.
        set_pat(0, 6, 4, "R7");
        set_pat(1, 0, 0, "R10");
        set_pat(2, 1, 3, "R7");
        set_pat(3, 3, 1, "R5");
        run_interval(1'b1);

        // R8 saturation on warps 0 and 1; just-below threshold on warp 3.
        set_pat(0, 12, 8, "R8");
        set_pat(1, 2, 18, "R8");
        set_pat(2, 1, 9, "R6");
        set_pat(3, 6, 3, "R7");
        run_interval(1'b0);

        // Single-access extremes, high ratio, idle warp.
        set_pat(0, 0, 1, "R4");
        set_pat(1, 1, 0, "R3");
        set_pat(2, 9, 1, "R5");
        set_pat(3, 0, 0, "R7");
        run_interval(1'b0);

        // R9: an empty interval; next readback shows re-profiled classes.
        for (int w = 0; w < NW; w++) set_pat(w, 0, 0, "R9");
        run_interval(1'b0);
        run_interval(1'b0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(10 * 20000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule